// File: doc/BRIEF.md
# Gigabit PCS Management Register Block

This block holds the management registers of a gigabit serial PCS. A simple synchronous request port carries a 5-bit register address, a write strobe with 16-bit write data, and a read strobe. Read data is registered and appears on `rdata_o` one clock after the read strobe.

Register 0 is implemented in full and drives the PCS control outputs: loopback, auto-negotiation enable, power down, isolate and unidirectional transmit. It also produces two single-cycle command pulses, one for a PCS reset and one for an auto-negotiation restart. Some bits of register 0 are hardwired so that the register always reports 1000 Mb/s full duplex. The power-down bit is sticky: only the register's own reset command clears it.

Status, identifier, advertisement, link-partner, expansion, next-page, extended-status and the two vendor-specific registers are read-only. They show the values on their input ports.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: Implemented addresses are 0–8, 15, 16 and 17. Address 1 reads `stat_i`, 2 `id_hi_i`, 3 `id_lo_i`, 4 `adv_i`, 5 `lp_abil_i`, 6 `an_exp_i`, 7 `np_tx_i`, 8 `np_rx_i`, 15 `ext_stat_i`, 16 `irq_ctl_i` and 17 `lpbk_ctl_i`. `rdata_o` takes the addressed value on the clock edge that samples `re_i` high and holds it otherwise.
- R2: A read of any other address returns 0x0000. A write to any other address changes no output and no register.
- R3: While `rst_ni` is low, and after it is released, the register holds its reset values. Loopback, power down, isolate and unidirectional are 0, auto-negotiation enable is 1, both pulses are 0, and register 0 reads 0x1140.
- R4: A write to address 0 without bit 15 set loads bit 14 (loopback), bit 12 (auto-negotiation enable), bit 10 (isolate) and bit 5 (unidirectional enable). The matching outputs change from the clock edge that samples the write.
- R5: Writing 1 to bit 11 sets power down. Writing 0 to bit 11 leaves it set.
- R6: Writing 1 to bit 15 of address 0 does three things. It raises `pcs_rst_o` for exactly one cycle, starting at the sampling edge. It returns every read/write field to its R3 value, which clears power down. It ignores all other bits of that write, so no restart pulse is produced. Bit 15 always reads 0.
- R7: Writing 1 to bit 9 of address 0, with bit 15 clear, raises `an_restart_o` for exactly one cycle starting at the sampling edge. Bit 9 always reads 0.
- R8: In register 0, bits 13, 7 and 4:0 always read 0 and bits 8 and 6 always read 1. Writes to these bits have no effect.
- R9: Writes to addresses 1–8 and 15–17 leave register 0 and all control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| stat_i | input | 16 | Status register value (address 1) |
| id_hi_i | input | 16 | Identifier upper word (address 2) |
| id_lo_i | input | 16 | Identifier lower word (address 3) |
| adv_i | input | 16 | Advertisement register (address 4) |
| lp_abil_i | input | 16 | Link partner ability (address 5) |
| an_exp_i | input | 16 | Negotiation expansion (address 6) |
| np_tx_i | input | 16 | Next page transmit (address 7) |
| np_rx_i | input | 16 | Next page receive (address 8) |
| ext_stat_i | input | 16 | Extended status (address 15) |
| irq_ctl_i | input | 16 | Vendor interrupt control (address 16) |
| lpbk_ctl_i | input | 16 | Vendor loopback control (address 17) |
| pcs_rst_o | output | 1 | One-cycle PCS reset command |
| an_restart_o | output | 1 | One-cycle negotiation restart command |
| loopback_o | output | 1 | Loopback enable |
| an_en_o | output | 1 | Auto-negotiation enable |
| power_down_o | output | 1 | Transceiver power down |
| isolate_o | output | 1 | Isolate enable |
| unidir_o | output | 1 | Transmit without established link |

## Verification
The assertions check on every cycle the things that can be seen from one or two adjacent cycles:
- both command pulses last one cycle and are caused by the right write;
- the reset command lands the control outputs on their reset values;
- power down is never released except by that command;
- the outputs do not move without a write to address 0;
- the hardwired bits of register 0 and the zero reads of unimplemented addresses hold.

Only the bench scenarios can show the full value sequences. These include register 0 read-back after chains of writes, the sticky bit surviving a zero write and then falling to a reset command, the reset command overriding other bits in the same write, and every placeholder address returning its own input.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;
  parameter int ADDR_W = 5;
  parameter int DATA_W = 16;
  localparam int NUM_ADDR = 1 << ADDR_W;

  // addresses 0..8, 15, 16, 17
  localparam logic [NUM_ADDR-1:0] IMPL_MASK = NUM_ADDR'(32'h0003_81FF);

  localparam int B_RESET   = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPD_LSB = 13;
  localparam int B_AN_EN   = 12;
  localparam int B_PDOWN   = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUPLEX  = 8;
  localparam int B_COLTEST = 7;
  localparam int B_SPD_MSB = 6;
  localparam int B_UNIDIR  = 5;

  typedef struct packed {
    logic loopback;
    logic an_en;
    logic pdown;
    logic isolate;
    logic unidir;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{loopback: 1'b0, an_en: 1'b1, pdown: 1'b0,
                                 isolate: 1'b0, unidir: 1'b0};
endpackage

// File: rtl/pcs_ctrl_reg.sv
module pcs_ctrl_reg
  import pcs_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              rst_pulse_o,
  output logic              restart_pulse_o,
  output logic [DATA_W-1:0] rd_o
);
  ctrl_t ctrl_q;
  logic  rst_p_q, restart_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= CTRL_RST;
      rst_p_q     <= 1'b0;
      restart_p_q <= 1'b0;
    end else begin
      rst_p_q     <= 1'b0;
      restart_p_q <= 1'b0;
      if (wr_i) begin
        if (wdata_i[B_RESET]) begin
          // reset command overrides every other bit of the write
          ctrl_q  <= CTRL_RST;
          rst_p_q <= 1'b1;
        end else begin
          ctrl_q.loopback <= wdata_i[B_LOOP];
          ctrl_q.an_en    <= wdata_i[B_AN_EN];
          ctrl_q.pdown    <= ctrl_q.pdown | wdata_i[B_PDOWN];
          ctrl_q.isolate  <= wdata_i[B_ISO];
          ctrl_q.unidir   <= wdata_i[B_UNIDIR];
          restart_p_q     <= wdata_i[B_RESTART];
        end
      end
    end
  end

  always_comb begin
    rd_o            = '0;
    rd_o[B_LOOP]    = ctrl_q.loopback;
    rd_o[B_AN_EN]   = ctrl_q.an_en;
    rd_o[B_PDOWN]   = ctrl_q.pdown;
    rd_o[B_ISO]     = ctrl_q.isolate;
    rd_o[B_UNIDIR]  = ctrl_q.unidir;
    rd_o[B_DUPLEX]  = 1'b1;
    rd_o[B_SPD_MSB] = 1'b1;
  end

  assign ctrl_o          = ctrl_q;
  assign rst_pulse_o     = rst_p_q;
  assign restart_pulse_o = restart_p_q;
endmodule

// File: rtl/pcs_rd_mux.sv
module pcs_rd_mux
  import pcs_mgmt_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             re_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_ADDR-1:0][DATA_W-1:0]  regs_i,
  output logic [DATA_W-1:0]                rdata_o
);
  logic [DATA_W-1:0] rdata_q, rd_sel;

  assign rd_sel = IMPL_MASK[addr_i] ? regs_i[addr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_sel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
  import pcs_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] id_hi_i,
  input  logic [DATA_W-1:0] id_lo_i,
  input  logic [DATA_W-1:0] adv_i,
  input  logic [DATA_W-1:0] lp_abil_i,
  input  logic [DATA_W-1:0] an_exp_i,
  input  logic [DATA_W-1:0] np_tx_i,
  input  logic [DATA_W-1:0] np_rx_i,
  input  logic [DATA_W-1:0] ext_stat_i,
  input  logic [DATA_W-1:0] irq_ctl_i,
  input  logic [DATA_W-1:0] lpbk_ctl_i,
  output logic              pcs_rst_o,
  output logic              an_restart_o,
  output logic              loopback_o,
  output logic              an_en_o,
  output logic              power_down_o,
  output logic              isolate_o,
  output logic              unidir_o
);
  ctrl_t                            ctrl;
  logic [DATA_W-1:0]                reg0;
  logic [NUM_ADDR-1:0][DATA_W-1:0]  regs;
  logic                             wr0;

  assign wr0 = we_i && (addr_i == '0);

  pcs_ctrl_reg u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_i            (wr0),
    .wdata_i         (wdata_i),
    .ctrl_o          (ctrl),
    .rst_pulse_o     (pcs_rst_o),
    .restart_pulse_o (an_restart_o),
    .rd_o            (reg0)
  );

  always_comb begin
    regs     = '0;
    regs[0]  = reg0;
    regs[1]  = stat_i;
    regs[2]  = id_hi_i;
    regs[3]  = id_lo_i;
    regs[4]  = adv_i;
    regs[5]  = lp_abil_i;
    regs[6]  = an_exp_i;
    regs[7]  = np_tx_i;
    regs[8]  = np_rx_i;
    regs[15] = ext_stat_i;
    regs[16] = irq_ctl_i;
    regs[17] = lpbk_ctl_i;
  end

  pcs_rd_mux u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  assign loopback_o   = ctrl.loopback;
  assign an_en_o      = ctrl.an_en;
  assign power_down_o = ctrl.pdown;
  assign isolate_o    = ctrl.isolate;
  assign unidir_o     = ctrl.unidir;
endmodule

// File: rtl/pcs_mgmt_regs_chk.sv
module pcs_mgmt_regs_chk
  import pcs_mgmt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              pcs_rst_o,
  input logic              an_restart_o,
  input logic              loopback_o,
  input logic              an_en_o,
  input logic              power_down_o,
  input logic              isolate_o,
  input logic              unidir_o
);
  // R6
  rst_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcs_rst_o |=> !pcs_rst_o);

  // R6
  rst_pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcs_rst_o |-> $past(we_i && addr_i == '0 && wdata_i[B_RESET]));

  // R6
  rst_values_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcs_rst_o |-> (!loopback_o && an_en_o && !power_down_o && !isolate_o
                   && !unidir_o && !an_restart_o));

  // R7
  restart_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |=> !an_restart_o);

  // R7
  restart_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |-> $past(we_i && addr_i == '0 && wdata_i[B_RESTART]
                           && !wdata_i[B_RESET]));

  // R5
  pdown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(power_down_o) && !pcs_rst_o) |-> power_down_o);

  // R9
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(we_i && addr_i == '0)) |->
      ($stable(loopback_o) && $stable(an_en_o) && $stable(power_down_o)
       && $stable(isolate_o) && $stable(unidir_o)));

  // R8
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && re_i && addr_i == '0) |->
      (rdata_o[B_DUPLEX] && rdata_o[B_SPD_MSB] && !rdata_o[B_SPD_LSB]
       && !rdata_o[B_COLTEST] && rdata_o[4:0] == 5'd0
       && !rdata_o[B_RESET] && !rdata_o[B_RESTART]));

  // R2
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && re_i && !IMPL_MASK[addr_i]) |-> rdata_o == '0);
endmodule

bind pcs_mgmt_regs pcs_mgmt_regs_chk u_chk (.*);

// File: tb/pcs_mgmt_regs_test.sv
module pcs_mgmt_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pcs_rst, an_restart, loopback, an_en, pdown, isolate, unidir;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [15:0] ph(input int a);
    return 16'hA000 ^ 16'(a * 16'h0513);
  endfunction

  pcs_mgmt_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata),
    .stat_i(ph(1)), .id_hi_i(ph(2)), .id_lo_i(ph(3)), .adv_i(ph(4)),
    .lp_abil_i(ph(5)), .an_exp_i(ph(6)), .np_tx_i(ph(7)), .np_rx_i(ph(8)),
    .ext_stat_i(ph(15)), .irq_ctl_i(ph(16)), .lpbk_ctl_i(ph(17)),
    .pcs_rst_o(pcs_rst), .an_restart_o(an_restart), .loopback_o(loopback),
    .an_en_o(an_en), .power_down_o(pdown), .isolate_o(isolate),
    .unidir_o(unidir)
  );

  logic [6:0] outs;
  assign outs = {pcs_rst, an_restart, loopback, an_en, pdown, isolate, unidir};

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  // {addr, wdata, expected outputs after write, expected reg0 read}
  localparam logic [43:0] VEC [14] = '{
    {5'd0,  16'h7FFF, 7'b0111111, 16'h5D60},  // R4 R5 R7
    {5'd0,  16'h0000, 7'b0000100, 16'h0940},  // R5 sticky
    {5'd0,  16'h8000, 7'b1001000, 16'h1140},  // R6
    {5'd0,  16'h4000, 7'b0010000, 16'h4140},  // R4
    {5'd0,  16'h1020, 7'b0001001, 16'h1160},  // R4
    {5'd0,  16'h0400, 7'b0000010, 16'h0540},  // R4
    {5'd4,  16'hFFFF, 7'b0000010, 16'h0540},  // R9
    {5'd9,  16'hFFFF, 7'b0000010, 16'h0540},  // R2
    {5'd0,  16'hA2FF, 7'b1001000, 16'h1140},  // R6 overrides
    {5'd0,  16'h0A00, 7'b0100100, 16'h0940},  // R5 R7
    {5'd0,  16'h1000, 7'b0001100, 16'h1940},  // R5 sticky
    {5'd0,  16'h80A0, 7'b1001000, 16'h1140},  // R6 clears pd
    {5'd0,  16'h20C0, 7'b0000000, 16'h0140},  // R8
    {5'd0,  16'h031F, 7'b0100000, 16'h0140}   // R7 R8
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    // R3 state during reset
    repeat (3) @(negedge clk);
    chk(outs == 7'b0001000, "R3", 32'(outs), 32'(7'b0001000));
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs == 7'b0001000, "R3", 32'(outs), 32'(7'b0001000));
    rd(5'd0, v);
    chk(v == 16'h1140, "R3", 32'(v), 32'h1140);

    // vector table
    foreach (VEC[i]) begin
      wr(VEC[i][43:39], VEC[i][38:23]);
      chk(outs == VEC[i][22:16], "R4/R5/R6/R7/R9 outputs", 32'(outs),
          32'(VEC[i][22:16]));
      rd(5'd0, v);
      chk(outs[6:5] == 2'b00, "R6/R7 pulse width", 32'(outs[6:5]), 32'd0);
      chk(v == VEC[i][15:0], "R8 reg0 readback", 32'(v), 32'(VEC[i][15:0]));
    end

    // R1 placeholder reads
    for (int a = 1; a < 32; a++) begin
      logic [15:0] e;
      e = (a <= 8 || a == 15 || a == 16 || a == 17) ? ph(a) : 16'h0000;
      rd(5'(a), v);
      if (e != 16'h0000) chk(v == e, "R1", 32'(v), 32'(e));
      else               chk(v == e, "R2", 32'(v), 32'(e));
    end

    // R1 read data holds without re
    rd(5'd2, v);
    @(negedge clk); addr = 5'd3;
    @(negedge clk);
    chk(rdata == ph(2), "R1 hold", 32'(rdata), 32'(ph(2)));

    // R3 asynchronous reset mid-operation
    wr(5'd0, 16'h4C20);
    chk(outs == 7'b0010111, "R5", 32'(outs), 32'(7'b0010111));
    #1 rst_n = 1'b0;
    #1 chk(outs == 7'b0001000, "R3 async", 32'(outs), 32'(7'b0001000));
    @(negedge clk); rst_n = 1'b1;
    rd(5'd0, v);
    chk(v == 16'h1140, "R3", 32'(v), 32'h1140);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule